// File: doc/BRIEF.md
# Rotate-and-Mask Execution Unit

This unit executes the rotate-left-then-mask family of integer instructions. Each accepted instruction word carries a rotate amount, the first and last positions of a bit mask, and a record bit. The unit rotates the source operand left by the rotate amount and keeps only the bits that the mask selects. It registers the result and presents it one clock later, together with a valid strobe and, if the record bit was set, a three-way sign classification of the result.

Mask positions count from the most significant bit, which is position 0. The mask is a contiguous run of ones from the first position to the last. If the first position lies beyond the last, the run wraps around through the word boundary. The datapath width is a parameter. For 32 the five-bit mask fields address the whole word. For 64 they address the low word, so each position is offset by 32 and the rotate acts on the full 64 bits.

Top module: `rotm_unit`

## Requirements
- R1: The instruction word fields are taken as follows, with bit 0 as the least significant bit: the opcode from bits 31..26, the rotate amount from bits 15..11, the mask first position from bits 10..6, the mask last position from bits 5..1, and the record bit from bit 0.
- R2: When the first position is not greater than the last, the mask has ones exactly at positions first through last inclusive. Position 0 is the most significant bit, so position p is vector bit W-1-p.
- R3: When the first position is greater than the last, the mask has ones everywhere except positions last+1 through first-1. A first position equal to last+1 therefore gives an all-ones mask.
- R4: When the first and last positions are equal, the mask has exactly one bit set.
- R5: The source operand is rotated left by the rotate amount modulo W. Bits leaving the top re-enter at the bottom.
- R6: The output data equals the rotated operand AND the mask. It appears one clock after the instruction is accepted, and res_valid is high in that cycle.
- R7: An instruction is accepted only when in_valid is high and the opcode equals the parameter OPCODE (default 21). In the cycle after any other input, res_valid is low and res_data, rec_req and sign_flags keep their previous values.
- R8: For an accepted instruction with record bit 1, rec_req is 1 and sign_flags is one-hot: bit 2 set for a negative result (MSB 1), bit 0 set for a zero result, and bit 1 set otherwise. With record bit 0, rec_req and sign_flags are 0.
- R9: While rst_n is low, and in the first cycle after it rises, res_valid, res_data, rec_req and sign_flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operand are present |
| insn | input | 32 | Instruction word |
| src_val | input | W | Source operand |
| res_valid | output | 1 | Result strobe, one clock after acceptance |
| res_data | output | W | Rotated and masked result |
| rec_req | output | 1 | Condition flag update requested |
| sign_flags | output | 3 | One-hot {negative, positive, zero} of res_data |

## Verification
The cases hardest to reach from the ports are the wrapped masks at their edges. These include a first position exactly one past the last, which must give all ones, and single-bit masks at both ends of the word. Random operands with random mask fields seldom hit these edges. The stimulus therefore sweeps every one of the 1024 first/last pairs, each with a random rotate amount and operand. A bench model builds the expected mask one position at a time. Directed words then cover rotate amounts 0 and 31, zero and negative results, and rejected opcodes.

// File: rtl/rotm_pkg.sv
package rotm_pkg;
  localparam int INSN_W    = 32;
  localparam int FIELD_W   = 5;
  localparam int OPC_W     = 6;
  localparam int OPC_LSB   = 26;
  localparam int ROT_LSB   = 11;
  localparam int FIRST_LSB = 6;
  localparam int LAST_LSB  = 1;
  localparam int REC_BIT   = 0;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
  } rotm_flags_t;
endpackage

// File: rtl/rotm_fields.sv
module rotm_fields
  import rotm_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [INSN_W-1:0] insn,
  output logic [OPC_W-1:0]  opcode,
  output logic [IW-1:0]     rot_amt,
  output logic [IW-1:0]     first_pos,
  output logic [IW-1:0]     last_pos,
  output logic              rec_bit
);
  localparam int POS_OFS = W - 32;

  logic [FIELD_W-1:0] rot_f, first_f, last_f;

  assign opcode  = insn[OPC_LSB +: OPC_W];
  assign rot_f   = insn[ROT_LSB +: FIELD_W];
  assign first_f = insn[FIRST_LSB +: FIELD_W];
  assign last_f  = insn[LAST_LSB +: FIELD_W];
  assign rec_bit = insn[REC_BIT];

  generate
    if (IW == FIELD_W) begin : g_narrow
      assign rot_amt   = rot_f;
      assign first_pos = first_f;
      assign last_pos  = last_f;
    end else begin : g_wide
      assign rot_amt   = IW'(rot_f);
      assign first_pos = IW'(first_f) + IW'(POS_OFS);
      assign last_pos  = IW'(last_f) + IW'(POS_OFS);
    end
  endgenerate
endmodule

// File: rtl/rotm_mask_gen.sv
module rotm_mask_gen #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [IW-1:0] first_pos,
  input  logic [IW-1:0] last_pos,
  output logic [W-1:0]  mask
);
  // Ones from first_pos down to the LSB, minus ones below last_pos.
  // A reversed pair yields the inner gap, which is then inverted.
  function automatic logic [W-1:0] build_mask(input logic [IW-1:0] f,
                                              input logic [IW-1:0] l);
    logic [W-1:0] all1, head, tail, span;
    all1 = '1;
    head = all1 >> f;
    tail = (all1 >> l) >> 1;
    span = head ^ tail;
    return (f > l) ? ~span : span;
  endfunction

  assign mask = build_mask(first_pos, last_pos);
endmodule

// File: rtl/rotm_rotl.sv
module rotm_rotl #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [IW-1:0] amt,
  output logic [W-1:0]  dout
);
  function automatic logic [W-1:0] rotl(input logic [W-1:0] v,
                                        input logic [IW-1:0] a);
    logic [2*W-1:0] dbl;
    dbl = {v, v} << a;
    return dbl[2*W-1:W];
  endfunction

  assign dout = rotl(din, amt);
endmodule

// File: rtl/rotm_unit.sv
module rotm_unit
  import rotm_pkg::*;
#(
  parameter int W      = 32,
  parameter int OPCODE = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [W-1:0]      src_val,
  output logic              res_valid,
  output logic [W-1:0]      res_data,
  output logic              rec_req,
  output logic [2:0]        sign_flags
);
  localparam int IW = $clog2(W);

  logic [OPC_W-1:0] opc_w;
  logic [IW-1:0]    rot_w, first_w, last_w;
  logic             rec_w;
  logic [W-1:0]     mask_w, rot_val_w, masked_w;
  logic             accept_w;
  rotm_flags_t      flags_w;

  rotm_fields #(.W(W), .IW(IW)) u_fields (
    .insn(insn), .opcode(opc_w), .rot_amt(rot_w),
    .first_pos(first_w), .last_pos(last_w), .rec_bit(rec_w)
  );

  rotm_mask_gen #(.W(W), .IW(IW)) u_mask (
    .first_pos(first_w), .last_pos(last_w), .mask(mask_w)
  );

  rotm_rotl #(.W(W), .IW(IW)) u_rot (
    .din(src_val), .amt(rot_w), .dout(rot_val_w)
  );

  assign accept_w = in_valid && (opc_w == OPC_W'(OPCODE));
  assign masked_w = rot_val_w & mask_w;

  always_comb begin
    flags_w.neg  = masked_w[W-1];
    flags_w.zero = (masked_w == '0);
    flags_w.pos  = !flags_w.neg && !flags_w.zero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      rec_req    <= 1'b0;
      sign_flags <= '0;
    end else begin
      res_valid <= accept_w;
      if (accept_w) begin
        res_data   <= masked_w;
        rec_req    <= rec_w;
        sign_flags <= rec_w ? flags_w : 3'b000;
      end
    end
  end

  // R4: equal first and last positions select one bit
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_w == last_w) |-> $countones(mask_w) == 1);

  // R3: a wrapped mask keeps both of its end positions
  a_r3_wrap_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_w > last_w) |-> (mask_w[W-1-first_w] && mask_w[W-1-last_w]));

  // R5: rotation loses no bits
  a_r5_rot_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones(rot_val_w) == $countones(src_val));

  // R6: the result never leaves the mask of its instruction
  a_r6_result_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_data & ~$past(mask_w)) == '0);

  // R7: a strobe needs an input one cycle earlier
  a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid));

  // R7: rejected input leaves the outputs alone
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(res_data) && $stable(sign_flags));

  // R8: recorded results carry exactly one sign flag
  a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rec_req |-> $onehot(sign_flags));

  // R8: no flags without a record request
  a_r8_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_req |-> sign_flags == 3'b000);
endmodule

// File: tb/test_rotm_unit.sv
module test_rotm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int OPC = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [W-1:0] src_val = '0;
  logic res_valid, rec_req;
  logic [W-1:0] res_data;
  logic [2:0] sign_flags;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotm_unit #(.W(W), .OPCODE(OPC)) i_rotm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_val(src_val), .res_valid(res_valid), .res_data(res_data),
    .rec_req(rec_req), .sign_flags(sign_flags)
  );

  function automatic logic [W-1:0] ref_mask(int f, int l);
    logic [W-1:0] m = '0;
    for (int p = 0; p < W; p++) begin
      bit in_run = (f <= l) ? (p >= f && p <= l) : (p >= f || p <= l);
      m[W-1-p] = in_run;
    end
    return m;
  endfunction

  function automatic logic [W-1:0] ref_rotl(logic [W-1:0] v, int s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[(i + s) % W] = v[i];
    return r;
  endfunction

  function automatic logic [2:0] ref_flags(logic [W-1:0] r, bit rec);
    if (!rec) return 3'b000;
    if (r[W-1]) return 3'b100;
    if (r == '0) return 3'b001;
    return 3'b010;
  endfunction

  function automatic logic [31:0] mk(int opc, int s, int f, int l, bit rec, int junk);
    logic [31:0] w;
    w = 32'(junk);
    w[31:26] = 6'(opc);
    w[15:11] = 5'(s);
    w[10:6]  = 5'(f);
    w[5:1]   = 5'(l);
    w[0]     = rec;
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic run(string req, int s, int f, int l, bit rec, logic [W-1:0] v);
    logic [W-1:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    insn = mk(OPC, s, f, l, rec, $urandom);
    src_val = v;
    e = ref_rotl(v, s) & ref_mask(f, l);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(res_valid), 64'd1);
    check({req, " data"}, 64'(res_data), 64'(e));
    check({req, " R8 rec"}, 64'(rec_req), 64'(rec));
    check({req, " R8 flags"}, 64'(sign_flags), 64'(ref_flags(e, rec)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] prev_d;
    logic [2:0] prev_f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", 64'(res_valid), 0);
    check("R9 data", 64'(res_data), 0);
    check("R9 flags", 64'({rec_req, sign_flags}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", 64'({res_valid, rec_req, sign_flags}), 0);

    // R2 R3 R4: all first/last pairs, random rotate and operand
    for (int f = 0; f < W; f++)
      for (int l = 0; l < W; l++)
        run(f == l ? "R4" : (f > l ? "R3" : "R2"), $urandom_range(31), f, l,
            1'($urandom), $urandom);

    // R3: wrap with first = last+1 gives all ones
    run("R3 full", 0, 9, 8, 1'b0, 32'hDEAD_BEEF);
    // R2: mask from the MSB and to the LSB
    run("R2 top", 0, 0, 3, 1'b1, 32'hFFFF_FFFF);
    run("R2 bottom", 0, 28, 31, 1'b1, 32'hFFFF_FFFF);
    // R5: rotate by 0, 1 and 31, full mask
    run("R5 zero", 0, 0, 31, 1'b0, 32'h8000_0001);
    run("R5 one", 1, 0, 31, 1'b0, 32'h8000_0001);
    run("R5 max", 31, 0, 31, 1'b0, 32'h0000_0003);
    // R1: fields taken from the right bits (exact word)
    @(negedge clk);
    in_valid = 1'b1; insn = 32'h5400_2147; src_val = 32'h0000_00F0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 fields", 64'(res_data), 64'(ref_rotl(32'hF0, 4) & ref_mask(5, 3)));
    check("R1 rec", 64'(rec_req), 1);
    // R8: zero, negative and positive results
    run("R8 zero", 3, 10, 12, 1'b1, 32'h0);
    run("R8 neg", 0, 0, 0, 1'b1, 32'h8000_0000);
    run("R8 pos", 0, 31, 31, 1'b1, 32'h1);
    run("R6 rand", 7, 20, 4, 1'b1, 32'h1234_5678);

    // R7: wrong opcode and idle input leave outputs alone
    prev_d = res_data; prev_f = sign_flags;
    @(negedge clk);
    in_valid = 1'b1; insn = mk(OPC + 1, 4, 0, 31, 1'b1, 0); src_val = 32'hFFFF;
    @(negedge clk);
    check("R7 wrong opcode valid", 64'(res_valid), 0);
    check("R7 wrong opcode data", 64'(res_data), 64'(prev_d));
    check("R7 wrong opcode flags", 64'(sign_flags), 64'(prev_f));
    in_valid = 1'b0; insn = mk(OPC, 0, 0, 31, 1'b0, 0);
    @(negedge clk);
    check("R7 idle valid", 64'(res_valid), 0);
    check("R7 idle data", 64'(res_data), 64'(prev_d));

    // R6: random mix
    for (int k = 0; k < 300; k++)
      run("R6", $urandom_range(31), $urandom_range(31), $urandom_range(31),
          1'($urandom), $urandom);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule